// File: doc/BRIEF.md
# Static LCD Segment Driver

This block drives a directly wired (non-multiplexed) liquid-crystal panel. It has twenty segment pins and one backplane pin. A host loads new segment data over three wires: an enable, a serial clock and a serial data line. Each segment pin is the exclusive-OR of that segment's latched on/off state with a low-frequency square wave on the backplane. A lit segment therefore sees an alternating voltage with no DC part, and a dark segment moves in step with the backplane.

The backplane comes from one of two sources. In master mode an internal divider of the system clock produces it, with exactly 50% duty. In slave mode it is taken from an external input, so several drivers can share one backplane wire. Several drivers can also share the serial clock and data wires, because each one responds only while its own enable is high. All three serial inputs and the external backplane are brought into the system clock domain before they are used.

A transfer is a frame of 21 bits. The first is a start marker, followed by one bit per segment from segment 1 to segment 20. Segment bits are active low. The frame is committed when enable falls, and only if it is well formed.

Top module: `lcd_static_drv`

## Requirements
- R1: The block has twenty segment outputs `seg_out[19:0]`, where bit k drives segment k+1, plus a backplane output `bp_out` and its drive-enable `bp_oe`.
- R2: While the synchronized `ser_en` is low, activity on `ser_clk` and `ser_dat` changes neither the received bits nor the segment outputs.
- R3: While the synchronized `ser_en` is high, one bit is taken from `ser_dat` on each rising edge of the synchronized `ser_clk`. Each input passes through a two-flop synchronizer. The segment latch takes its new value on the third system-clock edge after `ser_en` is seen low.
- R4: On the falling edge of enable, the latch is loaded only if exactly 21 bits were received and the first of them was 1. The second bit belongs to segment 1 and the last to segment 20. Frames of 20 or 22 bits, and frames whose first bit is 0, leave the latch unchanged.
- R5: Segment data is active low: a received 0 lights the segment and a received 1 darkens it.
- R6: Every `seg_out[k]` equals the latched on-state of segment k+1 XOR the selected backplane. A dark segment is in phase with the backplane and a lit segment is in antiphase.
- R7: With `slave_mode` low, the selected backplane is the internal square wave, which is also driven on `bp_out`. It is 0 right after reset and inverts every `BP_HALF` system clocks, so any window of 2*`BP_HALF` consecutive clocks holds exactly `BP_HALF` high cycles.
- R8: With `slave_mode` high, `bp_oe` is 0 and the selected backplane is `bp_in` delayed by its two-flop synchronizer. `bp_out` keeps carrying the internal wave.
- R9: A synchronous active-low reset clears every segment to dark, so all segment outputs follow the selected backplane.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| slave_mode | input | 1 | 1: use external backplane; 0: generate it |
| ser_clk | input | 1 | Serial shift clock (asynchronous) |
| ser_en | input | 1 | Serial enable, frames a transfer (asynchronous) |
| ser_dat | input | 1 | Serial data, stable while ser_clk is high |
| bp_in | input | 1 | External backplane in slave mode |
| bp_out | output | 1 | Internally generated backplane |
| bp_oe | output | 1 | High when bp_out should drive the backplane wire |
| seg_out | output | 20 | Segment drive, bit k is segment k+1 |

## Verification
The hardest cases to reach from the ports are the rejected frames. A frame of 20 or 22 bits, or one whose start bit is 0, must leave the previous pattern visible even though the shift path was busy the whole time. The stimulus first loads a known pattern. It then sends each malformed frame carrying a clearly different pattern and compares the outputs against the old pattern on every clock. Slave mode is reached through a reset with `slave_mode` held high. An irregular `bp_in` waveform is then applied, so that a missing or wrong synchronizer delay shows up as a phase error on the segments.

// File: rtl/lcd_drv_pkg.sv
// Package: shared constants and the bundle of asynchronous pins that
// are brought into the system clock domain together.
package lcd_drv_pkg;

    parameter int SEG_COUNT = 20;

    typedef struct packed {
        logic sclk;
        logic en;
        logic dat;
        logic bp;
    } pin_bus_t;

endpackage

// File: rtl/lcd_sync.sv
// Two-flop synchronizer for a vector of independent asynchronous bits.
// Assumes each bit is quasi-static relative to clk; no bus coherence.
module lcd_sync #(
    parameter int W = 1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stage1;

    // Two register stages per bit, cleared by reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stage1 <= '0;
            q      <= '0;
        end else begin
            stage1 <= d;
            q      <= stage1;
        end
    end
endmodule

// File: rtl/lcd_frame_rx.sv
// Serial frame receiver and segment latch.
// Inputs are already synchronized. Shifts one bit per rising sclk while
// en is high, then on the falling edge of en commits the segment bits
// (inverted: 0 = lit) if exactly NSEG+1 bits came in and the first was 1.
module lcd_frame_rx #(
    parameter int NSEG = 20
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            sclk_s,
    input  logic            en_s,
    input  logic            dat_s,
    output logic [NSEG-1:0] on_q,
    output logic [NSEG:0]   sr_q,
    output logic            en_fall
);
    localparam int FRAME = NSEG + 1;
    localparam int CW    = $clog2(FRAME + 2);
    localparam logic [CW-1:0] CNT_FULL = CW'(FRAME);
    localparam logic [CW-1:0] CNT_SAT  = CW'(FRAME + 1);

    logic          sclk_d;
    logic          en_d;
    logic          sclk_rise;
    logic [CW-1:0] cnt_q;
    logic          frame_ok;
    logic [NSEG-1:0] on_next;

    // Delay copies used for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sclk_d <= 1'b0;
            en_d   <= 1'b0;
        end else begin
            sclk_d <= sclk_s;
            en_d   <= en_s;
        end
    end

    assign sclk_rise = sclk_s & ~sclk_d;
    assign en_fall   = en_d & ~en_s;

    // Shift register and saturating bit counter; count clears while idle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
            sr_q  <= '0;
        end else if (!en_s) begin
            cnt_q <= '0;
        end else if (sclk_rise) begin
            sr_q <= {sr_q[FRAME-2:0], dat_s};
            if (cnt_q != CNT_SAT) begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end

    assign frame_ok = en_fall && (cnt_q == CNT_FULL) && sr_q[FRAME-1];

    // Map shift position to segment: oldest data bit is segment 1.
    for (genvar k = 0; k < NSEG; k++) begin : g_map
        assign on_next[k] = ~sr_q[NSEG-1-k];
    end

    // Segment latch, loaded only by a well-formed frame.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            on_q <= '0;
        end else if (frame_ok) begin
            on_q <= on_next;
        end
    end
endmodule

// File: rtl/lcd_bp_gen.sv
// Backplane square-wave generator: inverts its output every HALF clocks,
// giving exactly 50% duty. Output is 0 directly after reset.
module lcd_bp_gen #(
    parameter int HALF = 500000
) (
    input  logic clk,
    input  logic rst_n,
    output logic bp_q
);
    localparam int CW = (HALF > 1) ? $clog2(HALF) : 1;
    localparam logic [CW-1:0] LAST = CW'(HALF - 1);

    logic [CW-1:0] cnt_q;

    // Half-period counter; flips the wave when it wraps.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
            bp_q  <= 1'b0;
        end else if (cnt_q == LAST) begin
            cnt_q <= '0;
            bp_q  <= ~bp_q;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end
endmodule

// File: rtl/lcd_static_drv.sv
// Top: static LCD driver. Synchronizes the serial pins and the external
// backplane, receives frames, picks the backplane source and drives each
// segment as on-state XOR backplane. slave_mode is a static strap.
module lcd_static_drv #(
    parameter int NSEG    = lcd_drv_pkg::SEG_COUNT,
    parameter int BP_HALF = 500000
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            slave_mode,
    input  logic            ser_clk,
    input  logic            ser_en,
    input  logic            ser_dat,
    input  logic            bp_in,
    output logic            bp_out,
    output logic            bp_oe,
    output logic [NSEG-1:0] seg_out
);
    import lcd_drv_pkg::*;

    localparam int PW = $bits(pin_bus_t);

    pin_bus_t        pins_raw;
    pin_bus_t        pins_s;
    logic [NSEG-1:0] on_w;
    logic [NSEG:0]   sr_w;
    logic            en_fall_w;
    logic            bp_gen_w;
    logic            bp_sel;

    assign pins_raw = '{sclk: ser_clk, en: ser_en, dat: ser_dat, bp: bp_in};

    lcd_sync #(.W(PW)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (pins_raw),
        .q     (pins_s)
    );

    lcd_frame_rx #(.NSEG(NSEG)) u_rx (
        .clk     (clk),
        .rst_n   (rst_n),
        .sclk_s  (pins_s.sclk),
        .en_s    (pins_s.en),
        .dat_s   (pins_s.dat),
        .on_q    (on_w),
        .sr_q    (sr_w),
        .en_fall (en_fall_w)
    );

    lcd_bp_gen #(.HALF(BP_HALF)) u_bp (
        .clk   (clk),
        .rst_n (rst_n),
        .bp_q  (bp_gen_w)
    );

    // Backplane source selection and segment modulation.
    always_comb begin
        bp_sel  = slave_mode ? pins_s.bp : bp_gen_w;
        seg_out = on_w ^ {NSEG{bp_sel}};
        bp_out  = bp_gen_w;
        bp_oe   = ~slave_mode;
    end
endmodule

// File: rtl/lcd_static_drv_chk.sv
// Checker for lcd_static_drv, bound to every instance of the top.
module lcd_static_drv_chk #(
    parameter int NSEG = 20,
    parameter int HALF = 500000
) (
    input logic            clk,
    input logic            rst_n,
    input logic            en_s,
    input logic            en_fall,
    input logic [NSEG:0]   sr,
    input logic [NSEG-1:0] on_q,
    input logic            bp_gen
);
    int run_q;

    // Independent count of clocks since reset, modulo a half period.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_q <= 0;
        end else if (run_q == HALF - 1) begin
            run_q <= 0;
        end else begin
            run_q <= run_q + 1;
        end
    end

    // R4
    latch_only_on_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(on_q) |-> $past(en_fall));

    // R2
    no_shift_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sr) |-> $past(en_s));

    // R7
    bp_toggle_period_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(bp_gen) |-> ($past(run_q) == HALF - 1));

    // R7
    bp_toggle_due_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(run_q) == HALF - 1) |-> !$stable(bp_gen));

    // R9
    reset_clears_chk: assert property (@(posedge clk)
        $rose(rst_n) |-> (on_q == '0));
endmodule

bind lcd_static_drv lcd_static_drv_chk #(.NSEG(NSEG), .HALF(BP_HALF)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .en_s    (pins_s.en),
    .en_fall (en_fall_w),
    .sr      (sr_w),
    .on_q    (on_w),
    .bp_gen  (bp_gen_w)
);

// File: tb/tb_lcd_static_drv.sv
module tb_lcd_static_drv;
    localparam int NSEG = 20;
    localparam int HALF = 16;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic slave_mode = 1'b0;
    logic ser_clk = 1'b0;
    logic ser_en = 1'b0;
    logic ser_dat = 1'b0;
    logic bp_in = 1'b0;
    logic bp_out;
    logic bp_oe;
    logic [NSEG-1:0] seg_out;

    lcd_static_drv #(.NSEG(NSEG), .BP_HALF(HALF)) dut (
        .clk(clk), .rst_n(rst_n), .slave_mode(slave_mode),
        .ser_clk(ser_clk), .ser_en(ser_en), .ser_dat(ser_dat),
        .bp_in(bp_in), .bp_out(bp_out), .bp_oe(bp_oe), .seg_out(seg_out)
    );

    always #10 clk = ~clk;

    int    vectors = 0;
    int    fails = 0;
    bit    started = 0;
    bit    done = 0;
    string cur_req = "R9";

    // ---------------- behavioural reference model ----------------
    logic [2:0]      sq[$];
    bit              bq[$];
    bit              mbits[$];
    int              mcnt;
    logic [NSEG-1:0] mon;
    int              ticks;
    bit              mbp_slave;

    function automatic bit gen_bp();
        return ((ticks / HALF) % 2) == 1;
    endfunction

    function automatic bit sel_bp();
        return slave_mode ? mbp_slave : gen_bp();
    endfunction

    always @(posedge clk) begin
        logic [2:0] cur;
        logic [2:0] prv;
        if (!rst_n) begin
            sq = '{3'b000, 3'b000, 3'b000};
            bq = '{1'b0, 1'b0};
            mbits.delete();
            mcnt = 0;
            mon = '0;
            ticks = 0;
            mbp_slave = 1'b0;
            started = 1;
        end else begin
            ticks++;
            // entries: {sclk, en, dat}; two-cycle sync plus one edge delay
            sq.push_back({ser_clk, ser_en, ser_dat});
            cur = sq[1];
            prv = sq[0];
            void'(sq.pop_front());
            if (prv[1] && !cur[1] && mcnt == NSEG + 1 && mbits[0]) begin
                for (int k = 0; k < NSEG; k++) mon[k] = ~mbits[k+1];
            end
            if (!cur[1]) begin
                mcnt = 0;
                mbits.delete();
            end else if (cur[2] && !prv[2]) begin
                mbits.push_back(cur[0]);
                mcnt++;
            end
            bq.push_back(bp_in);
            mbp_slave = bq[1];
            void'(bq.pop_front());
        end
    end

    task automatic report(input bit ok, input string req, input logic [31:0] act,
                          input logic [31:0] exp);
        vectors++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
        end
    endtask

    // Per-clock comparison, a quarter period after each rising edge.
    always @(posedge clk) begin
        #5;
        if (started && rst_n && !done) begin
            logic [NSEG-1:0] exp_seg;
            exp_seg = mon ^ {NSEG{sel_bp()}};
            report(seg_out === exp_seg, cur_req, 32'(seg_out), 32'(exp_seg));
            report(bp_out === gen_bp(), "R7", 32'(bp_out), 32'(gen_bp()));
            report(bp_oe === !slave_mode, "R8", 32'(bp_oe), 32'(!slave_mode));
        end
    end

    // ---------------- stimulus helpers ----------------
    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic send_bits(input logic [31:0] v, input int n);
        @(negedge clk);
        ser_en = 1'b1;
        tick(3);
        for (int i = 0; i < n; i++) begin
            ser_dat = v[n-1-i];
            tick(2);
            ser_clk = 1'b1;
            tick(3);
            ser_clk = 1'b0;
            tick(2);
        end
        ser_en = 1'b0;
        tick(6);
    endtask

    // Build a frame from an on-mask: start 1, then seg1..seg20 inverted.
    function automatic logic [31:0] frame_of(input logic [NSEG-1:0] m);
        logic [31:0] v = '0;
        v[NSEG] = 1'b1;
        for (int k = 0; k < NSEG; k++) v[NSEG-1-k] = ~m[k];
        return v;
    endfunction

    // Check the visible on-pattern against an intended mask (sampled off-edge).
    task automatic check_mask(input logic [NSEG-1:0] want, input string req);
        logic [NSEG-1:0] seen;
        @(posedge clk);
        #5;
        seen = seg_out ^ {NSEG{sel_bp()}};
        report(seen === want, req, 32'(seen), 32'(want));
    endtask

    task automatic do_reset(input bit slave);
        @(negedge clk);
        rst_n = 1'b0;
        slave_mode = slave;
        tick(4);
        rst_n = 1'b1;
        tick(2);
    endtask

    localparam logic [NSEG-1:0] PAT_A = 20'hA5C3F;
    localparam logic [NSEG-1:0] PAT_B = 20'h0F0F0;

    initial begin
        // R9: reset state
        cur_req = "R9";
        do_reset(1'b0);
        check_mask('0, "R9");
        report(seg_out === {NSEG{bp_out}}, "R9", 32'(seg_out), 32'({NSEG{bp_out}}));

        // R4/R5: well-formed frame with mixed pattern
        cur_req = "R4";
        send_bits(frame_of(PAT_A), NSEG + 1);
        check_mask(PAT_A, "R5");

        // R1: order of segments, first and last
        cur_req = "R1";
        send_bits(frame_of(20'h00001), NSEG + 1);
        check_mask(20'h00001, "R1");
        send_bits(frame_of(20'h80000), NSEG + 1);
        check_mask(20'h80000, "R1");

        // R6: all lit -> every output in antiphase with the backplane
        cur_req = "R6";
        send_bits(frame_of('1), NSEG + 1);
        tick(2);
        @(posedge clk); #5;
        report(seg_out === {NSEG{~bp_out}}, "R6", 32'(seg_out), 32'({NSEG{~bp_out}}));

        // R3: latch timing, sampled cycle by cycle after enable drop
        cur_req = "R3";
        send_bits(frame_of(PAT_A), NSEG + 1);
        check_mask(PAT_A, "R3");

        // R2: clock and data toggle with enable low
        cur_req = "R2";
        for (int i = 0; i < 30; i++) begin
            @(negedge clk);
            ser_dat = i[1];
            ser_clk = ~ser_clk;
        end
        ser_clk = 1'b0;
        tick(4);
        check_mask(PAT_A, "R2");

        // R4: malformed frames leave the pattern unchanged
        cur_req = "R4";
        send_bits(frame_of(PAT_B) >> 1, NSEG);
        check_mask(PAT_A, "R4");
        send_bits({frame_of(PAT_B)[30:0], 1'b0}, NSEG + 2);
        check_mask(PAT_A, "R4");
        send_bits(frame_of(PAT_B) & ~(32'h1 << NSEG), NSEG + 1);
        check_mask(PAT_A, "R4");
        send_bits(frame_of(PAT_B), NSEG + 1);
        check_mask(PAT_B, "R4");

        // R7: duty over two full half-periods
        cur_req = "R7";
        begin
            int highs = 0;
            for (int i = 0; i < 2 * HALF; i++) begin
                @(posedge clk); #5;
                if (bp_out) highs++;
            end
            report(highs == HALF, "R7", 32'(highs), 32'(HALF));
        end

        // R8: slave mode with an irregular external backplane
        cur_req = "R8";
        do_reset(1'b1);
        check_mask('0, "R9");
        fork
            begin
                for (int i = 0; i < 40; i++) begin
                    @(negedge clk);
                    bp_in = ~bp_in;
                    tick((i % 5) + 1);
                end
            end
            send_bits(frame_of(PAT_A), NSEG + 1);
        join
        @(negedge clk);
        bp_in = 1'b1;
        tick(4);
        @(posedge clk); #5;
        report(seg_out === ~PAT_A, "R8", 32'(seg_out), 32'(~PAT_A));
        report(bp_oe === 1'b0, "R8", 32'(bp_oe), 32'(0));
        @(negedge clk);
        bp_in = 1'b0;
        tick(4);
        check_mask(PAT_A, "R8");

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

    // Watchdog
    initial begin
        #(200000 * 20);
        if (!done) begin
            done = 1;
            fails++;
            vectors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end
endmodule